// File: doc/BRIEF.md
# Slotted Serial Audio Frame Port

This block moves one 8-bit mono sample per frame across a serial link. It acts as the timing master of the link. It produces a serial bit clock at half the rate of the system clock, so each bit lasts two system-clock cycles. It also produces a one-bit frame-sync pulse, drives the serial output and samples the serial input. The sample is carried in slot 0, the first slot of the frame. The first data bit comes one bit after the sync pulse. The most significant bit is sent first.

A 4-bit frame-length code selects the frame size:
- Code `0100` gives a 16-bit frame. Slot 1 is then left idle: the output is held low and the input is ignored.
- Code `0000`, and every other code, gives an 8-bit frame.

On the parallel side, a producer writes bytes into a one-deep transmit holding register using a valid/ready handshake. A consumer takes received bytes from a receive register when a one-cycle valid strobe marks a new byte. If a frame starts with the holding register empty, the previous byte is sent again and an underrun flag is raised for that frame.

Top module: `sap_frame_port`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, the block resets. After that edge, `ser_clk`, `frm_sync`, `ser_out`, `rx_valid` and `tx_underrun` are 0 and `tx_ready` is 1.
- R2: Out of reset, `ser_clk` toggles on every `clk` cycle. `frm_sync` and `ser_out` change only on the `clk` edge where `ser_clk` rises.
- R3: `frm_sync` is high for exactly one bit period. That period is the last bit of each frame, and bit 0 of the next frame follows it directly. The first bit period after reset is such a sync bit.
- R4: The frame length is measured from one sync bit to the next. Code `4'b0000` gives 8 bit periods, code `4'b0100` gives 16, and every other code gives 8. A new code that is applied before a frame starts is used for that whole frame.
- R5: In bit periods 0 to 7 of a frame, `ser_out` carries the frame's byte, most significant bit in bit 0. The byte is taken from the holding register when bit 0 starts.
- R6: In a 16-bit frame, `ser_out` is 0 during bit periods 8 to 15.
- R7: `ser_in` is sampled on each falling `ser_clk` edge of bit periods 0 to 7, most significant bit first. After the bit-7 sample, `rx_data` takes the byte and `rx_valid` is high for one `clk` cycle. `ser_in` in bit periods 8 to 15 has no effect: `rx_data` does not change and there is no extra `rx_valid`.
- R8: `tx_ready` is 1 while the holding register is empty. A byte is accepted on a `clk` edge where both `tx_valid` and `tx_ready` are 1. `tx_ready` then stays 0 until a frame start takes the byte.
- R9: If the holding register is empty when a frame starts, the previous frame's byte is sent again (0 after reset) and `tx_underrun` is 1 for that frame. Otherwise `tx_underrun` is 0 for the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; each serial bit lasts two cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| fl_code | input | 4 | Frame-length code: 0100 gives 16 bits, all other codes give 8 |
| tx_data | input | 8 | Byte offered to the transmit holding register |
| tx_valid | input | 1 | Producer offers `tx_data` |
| tx_ready | output | 1 | Holding register is empty and can accept a byte |
| ser_in | input | 1 | Serial receive data |
| ser_clk | output | 1 | Serial bit clock |
| frm_sync | output | 1 | One-bit frame-sync pulse in the last bit of each frame |
| ser_out | output | 1 | Serial transmit data |
| rx_data | output | 8 | Most recently received byte |
| rx_valid | output | 1 | One-cycle strobe when a new byte lands in `rx_data` |
| tx_underrun | output | 1 | The current frame repeats the previous byte because no new byte was ready |

## Verification
Some behaviours are checked by assertions on every cycle:
- the sync pulse drops after one bit period;
- the serial output changes only when the bit clock rises;
- the serial output is low in slot 1;
- the receive strobe lasts one cycle and comes only after a bit-7 sample, and the receive register holds its value between strobes;
- the handshake and the underrun flag follow the state of the holding register at each frame start.

Other behaviours can only be shown by the bench's scenarios. These are the actual frame lengths for each code, including the codes that fall back to 8 bits, and the bit order of bytes on the wire in both directions. They also include the chain of loaded bytes across frames and the exact repeated byte after an underrun.

// File: rtl/sap_pkg.sv
// Package: shared constants and helpers of the slotted serial audio port.
// Assumes the frame-length code is always FL_W bits wide.
package sap_pkg;
    localparam int FL_W = 4;
    localparam logic [FL_W-1:0] FL_CODE_LONG = 4'b0100;

    // Frame length in bit periods for a code: long code gives two slots, others one.
    function automatic int frame_bits(input logic [FL_W-1:0] code, input int data_w);
        return (code == FL_CODE_LONG) ? 2 * data_w : data_w;
    endfunction
endpackage

// File: rtl/sap_slot_timer.sv
// Module: bit and frame timing of the port. It toggles the serial clock every
// system cycle, counts bit periods on rising serial edges and raises the sync
// pulse in the last bit of each frame. It wraps to bit 0 after a sync bit, so a
// frame-length change takes effect cleanly at the next frame.
// Assumes CNT_W can hold 2*DATA_W-1.
module sap_slot_timer
    import sap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(2 * DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FL_W-1:0]  fl_code,
    output logic             ser_clk,
    output logic             frm_sync,
    output logic             rise_en,
    output logic             fall_en,
    output logic             frame_start,
    output logic [CNT_W-1:0] bit_idx,
    output logic [CNT_W-1:0] bit_nxt,
    output logic             frm_act,
    output logic             frm_act_nxt
);
    logic             sck_q;
    logic             run_q;
    logic             sync_q;
    logic             frm_q;
    logic [CNT_W-1:0] bit_q;
    logic [CNT_W-1:0] last_idx;

    assign last_idx    = CNT_W'(frame_bits(fl_code, DATA_W) - 1);
    assign rise_en     = ~sck_q;
    assign fall_en     = sck_q;
    assign frame_start = rise_en && run_q && sync_q;
    assign frm_act_nxt = frm_q || frame_start;

    // Next bit index: the first bit after reset is a sync bit; a sync bit is followed by bit 0.
    always_comb begin
        if (!run_q)      bit_nxt = last_idx;
        else if (sync_q) bit_nxt = '0;
        else             bit_nxt = bit_q + 1'b1;
    end

    // Free-running serial clock at half the system rate.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= ~sck_q;
    end

    // Advance the bit counter, sync pulse and frame-active flag on rising serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            sync_q <= 1'b0;
            frm_q  <= 1'b0;
            bit_q  <= '0;
        end else if (rise_en) begin
            run_q  <= 1'b1;
            bit_q  <= bit_nxt;
            sync_q <= (bit_nxt >= last_idx);
            frm_q  <= frm_act_nxt;
        end
    end

    assign ser_clk  = sck_q;
    assign frm_sync = sync_q;
    assign bit_idx  = bit_q;
    assign frm_act  = frm_q;

    // R3: a sync bit is always followed by a non-sync bit.
    a_r3_sync_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_en && sync_q) |=> !sync_q);
endmodule

// File: rtl/sap_tx_slot.sv
// Module: transmit side. It holds one byte from the parallel handshake, moves it
// into the frame byte at each frame start (or repeats the old byte and flags
// underrun), and drives the slot-0 bits MSB first on rising serial edges.
// Assumes frame_start is only ever high together with rise_en.
module sap_tx_slot #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_en,
    input  logic              frame_start,
    input  logic              slot_nxt,
    input  logic [CNT_W-1:0]  bit_nxt,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              ser_out,
    output logic              tx_underrun
);
    logic [DATA_W-1:0] hold_q;
    logic              hold_full_q;
    logic [DATA_W-1:0] cur_q;
    logic [DATA_W-1:0] byte_nxt;
    logic [DATA_W-1:0] byte_sh;
    logic              txd_q;
    logic              und_q;
    logic              accept;

    assign accept   = tx_valid && !hold_full_q;
    assign byte_nxt = (frame_start && hold_full_q) ? hold_q : cur_q;
    assign byte_sh  = byte_nxt << bit_nxt;

    // Holding register: fill on handshake, empty when a frame start takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
        end else if (accept) begin
            hold_q      <= tx_data;
            hold_full_q <= 1'b1;
        end else if (frame_start) begin
            hold_full_q <= 1'b0;
        end
    end

    // Frame byte and underrun flag, both updated once per frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            und_q <= 1'b0;
        end else if (frame_start) begin
            cur_q <= byte_nxt;
            und_q <= !hold_full_q;
        end
    end

    // Serial output: next slot-0 bit on each rising edge, low elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n)       txd_q <= 1'b0;
        else if (rise_en) txd_q <= slot_nxt ? byte_sh[DATA_W-1] : 1'b0;
    end

    assign tx_ready    = !hold_full_q;
    assign ser_out     = txd_q;
    assign tx_underrun = und_q;

    // R2: the serial output only moves on a rising serial edge.
    a_r2_txd_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_en |=> $stable(txd_q));
    // R8: an accepted byte makes the register busy.
    a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);
    // R9: an empty register at frame start raises underrun.
    a_r9_underrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !hold_full_q) |=> und_q);
    // R9: a full register at frame start clears underrun.
    a_r9_underrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && hold_full_q) |=> !und_q);
endmodule

// File: rtl/sap_rx_slot.sv
// Module: receive side. It shifts the serial input in MSB first on falling
// serial edges inside slot 0 and publishes the byte with a one-cycle strobe
// after the last slot bit.
// Assumes in_slot and last_bit are qualified by the caller from the bit index.
module sap_rx_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_en,
    input  logic              in_slot,
    input  logic              last_bit,
    input  logic              ser_in,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);
    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] captured;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;
    logic              take;

    assign captured = {shift_q[DATA_W-2:0], ser_in};
    assign take     = fall_en && in_slot;

    // Shift register: collects slot-0 bits on falling serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n)    shift_q <= '0;
        else if (take) shift_q <= captured;
    end

    // Output register and strobe: loaded on the last slot-0 sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= take && last_bit;
            if (take && last_bit) data_q <= captured;
        end
    end

    assign rx_data  = data_q;
    assign rx_valid = valid_q;

    // R7: the strobe lasts one cycle.
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R7: the received byte only changes together with the strobe.
    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data));
endmodule

// File: rtl/sap_frame_port.sv
// Module: top of the slotted serial audio frame port. It ties the timer, the
// transmit slot and the receive slot together and derives the slot-0 window
// from the bit counter.
// Assumes one mono sample per frame in slot 0; slot 1 (long frames) is idle.
module sap_frame_port
    import sap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FL_W-1:0]   fl_code,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              ser_in,
    output logic              ser_clk,
    output logic              frm_sync,
    output logic              ser_out,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              tx_underrun
);
    localparam int CNT_W = $clog2(2 * DATA_W);
    localparam logic [CNT_W-1:0] SLOT_END = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(DATA_W - 1);

    logic             rise_en;
    logic             fall_en;
    logic             frame_start;
    logic [CNT_W-1:0] bit_idx;
    logic [CNT_W-1:0] bit_nxt;
    logic             frm_act;
    logic             frm_act_nxt;
    logic             slot_nxt;
    logic             slot_cur;

    assign slot_nxt = frm_act_nxt && (bit_nxt < SLOT_END);
    assign slot_cur = frm_act && (bit_idx < SLOT_END);

    sap_slot_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .fl_code     (fl_code),
        .ser_clk     (ser_clk),
        .frm_sync    (frm_sync),
        .rise_en     (rise_en),
        .fall_en     (fall_en),
        .frame_start (frame_start),
        .bit_idx     (bit_idx),
        .bit_nxt     (bit_nxt),
        .frm_act     (frm_act),
        .frm_act_nxt (frm_act_nxt)
    );

    sap_tx_slot #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_en     (rise_en),
        .frame_start (frame_start),
        .slot_nxt    (slot_nxt),
        .bit_nxt     (bit_nxt),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .ser_out     (ser_out),
        .tx_underrun (tx_underrun)
    );

    sap_rx_slot #(.DATA_W(DATA_W)) i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_en  (fall_en),
        .in_slot  (slot_cur),
        .last_bit (bit_idx == SLOT_LAST),
        .ser_in   (ser_in),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    // R6: no data is driven outside slot 0.
    a_r6_slot1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_act && bit_idx >= SLOT_END) |-> !ser_out);
    // R7: a strobe only follows a falling-edge sample of the last slot-0 bit.
    a_r7_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(fall_en && frm_act && bit_idx == SLOT_LAST));
endmodule

// File: tb/test_sap_frame_port.sv
// Directed bench: acts as the serial partner and the parallel producer/consumer.
module test_sap_frame_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] fl_code = 4'b0000;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       ser_in = 1'b0;
    logic       ser_clk, frm_sync, ser_out, rx_valid, tx_underrun;
    logic [7:0] rx_data;

    always #10 clk = ~clk;

    sap_frame_port i_sap_frame_port (
        .clk(clk), .rst_n(rst_n), .fl_code(fl_code), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .ser_in(ser_in),
        .ser_clk(ser_clk), .frm_sync(frm_sync), .ser_out(ser_out),
        .rx_data(rx_data), .rx_valid(rx_valid), .tx_underrun(tx_underrun)
    );

    int total = 0;
    int bad = 0;
    int r2_bad = 0;
    int vcount = 0;
    bit done = 0;
    logic prev_sck = 0, prev_sync = 0, prev_txd = 0, rose = 0;
    logic [7:0] last_rx = 0;
    logic [7:0] exp_last_tx = 8'h00;
    logic [7:0] hold_byte = 8'h00;
    bit hold_pending = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One system cycle, observed at the falling clk edge.
    task automatic step();
        @(negedge clk);
        rose = ser_clk && !prev_sck;
        if (rst_n) begin
            if (ser_clk == prev_sck) r2_bad++;
            if (!rose && (frm_sync != prev_sync || ser_out != prev_txd)) r2_bad++;
        end
        prev_sck = ser_clk;
        prev_sync = frm_sync;
        prev_txd = ser_out;
        if (rx_valid) begin
            vcount++;
            last_rx = rx_data;
        end
    endtask

    task automatic wait_rise();
        do begin
            step();
            tx_valid = 1'b0;
        end while (!rose);
    endtask

    // One frame after a sync bit: drive ser_in, collect ser_out, optionally load a byte.
    task automatic run_frame(input logic [7:0] rxb, input bit ld, input logic [7:0] ldb,
                             input int exp_len, input string tag);
        logic [7:0] seen = 0;
        logic [7:0] exp_tx;
        int idle_bad = 0;
        int len = 0;
        vcount = 0;
        for (int k = 0; k < 32; k++) begin
            wait_rise();
            if (k == 0) begin
                check("R9", {tag, " underrun flag"}, int'(tx_underrun), int'(!hold_pending));
                exp_tx = hold_pending ? hold_byte : exp_last_tx;
                exp_last_tx = exp_tx;
                hold_pending = 0;
                if (ld) begin
                    check("R8", {tag, " ready before load"}, int'(tx_ready), 1);
                    tx_data = ldb;
                    tx_valid = 1'b1;
                    hold_pending = 1;
                    hold_byte = ldb;
                end
            end
            if (k == 1) check("R8", {tag, " ready after load"}, int'(tx_ready), int'(!hold_pending));
            if (k < 8) begin
                seen[7-k] = ser_out;
                ser_in = rxb[7-k];
            end else begin
                if (ser_out) idle_bad++;
                ser_in = 1'b1;
            end
            if (frm_sync) begin
                len = k + 1;
                break;
            end
        end
        step();
        check("R4", {tag, " frame length"}, len, exp_len);
        check("R5", {tag, " transmitted byte"}, int'(seen), int'(exp_tx));
        if (exp_len > 8) check("R6", {tag, " slot 1 idle"}, idle_bad, 0);
        check("R7", {tag, " rx strobes"}, vcount, 1);
        check("R7", {tag, " rx byte"}, int'(last_rx), int'(rxb));
        check("R7", {tag, " rx data after slot 1"}, int'(rx_data), int'(rxb));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "ser_clk", int'(ser_clk), 0);
        check("R1", "frm_sync", int'(frm_sync), 0);
        check("R1", "ser_out", int'(ser_out), 0);
        check("R1", "rx_valid", int'(rx_valid), 0);
        check("R1", "tx_ready", int'(tx_ready), 1);
        check("R1", "tx_underrun", int'(tx_underrun), 0);
        rst_n = 1'b1;
        wait_rise();
        check("R3", "first bit is sync", int'(frm_sync), 1);
    endtask

    task automatic t_short();
        run_frame(8'hA5, 1, 8'h3C, 8, "short0");
        run_frame(8'h5A, 1, 8'h81, 8, "short1");
        run_frame(8'hFF, 1, 8'h00, 8, "short2");
        check("R2", "short clock and edges", r2_bad, 0);
        fl_code = 4'b0100;
    endtask

    task automatic t_long();
        run_frame(8'h96, 1, 8'hC3, 16, "long0");
        run_frame(8'h01, 1, 8'h7E, 16, "long1");
        run_frame(8'h80, 0, 8'h00, 16, "long2");
        check("R2", "long clock and edges", r2_bad, 0);
    endtask

    task automatic t_underrun();
        run_frame(8'h3E, 0, 8'h00, 16, "under0");
        run_frame(8'h00, 1, 8'h55, 16, "under1");
        run_frame(8'hC7, 0, 8'h00, 16, "under2");
        fl_code = 4'b1010;
    endtask

    task automatic t_other_codes();
        run_frame(8'h69, 1, 8'hE1, 8, "code1010");
        fl_code = 4'b1111;
        run_frame(8'h12, 0, 8'h00, 8, "code1111a");
        run_frame(8'hED, 0, 8'h00, 8, "code1111b");
        check("R2", "other clock and edges", r2_bad, 0);
    endtask

    initial begin
        t_reset();
        t_short();
        t_long();
        t_underrun();
        t_other_codes();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule